// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software sets up through a small byte-wide register port. It counts down one step on each pulse of an external tick strobe. Each tick stands for a long interval, so the count does not advance on every clock.

The first time the count runs out, the block does three things:
- it sets a sticky timeout flag;
- it raises an interrupt that software can mask;
- it reloads the count from the programmed initial value and keeps counting.

If software does not write the reload register before the count runs out again, the second expiry sets a second-timeout flag. It also issues a one-cycle reset request, unless the no-reboot bit is set.

If the second stage runs out while the second-timeout flag is still set from an earlier second expiry, the block sets a boot-failure flag. That case means the system was asked to reset but kept running. All flags are cleared by writing one to them.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the following hold:
  - halt bit = 1, no-reboot = 0, interrupt enable = 0;
  - every status flag = 0, `irq` = 0, `rst_req` = 0;
  - initial value = 4 and current count = 4.
- R2: A write of any data to offset 0x00 loads the count from the initial value. The initial value is held at offset 0x01, in bits 5:0; legal values are 2 to 63. A read of 0x00 returns the count in bits 5:0. A reload write wins over a tick in the same cycle.
- R3: The halt bit is bit 3 of offset 0x09 (control bit 11). While it is 1, tick pulses leave the count unchanged. While it is 0, each tick lowers a nonzero count by one.
- R4: A tick that finds the count at 0 is an expiry, and the count reloads from the initial value. The first expiry after a reload write (or after a second expiry) does two things:
  - it sets the timeout flag, bit 3 of offset 0x04;
  - it sets the interrupt status flag, bit 5 of offset 0x15 (bit 13 of that register pair).
- R5: A second consecutive expiry, with no reload write in between, sets the second-timeout flag (bit 1 of offset 0x06) and drives `rst_req` high for exactly one clock. A reload write between the two expiries restarts the first stage.
- R6: The no-reboot bit is bit 1 of offset 0x18. While it is 1, a second expiry produces no `rst_req` pulse, but it still sets the second-timeout flag.
- R7: A second expiry that finds the second-timeout flag already set also sets the boot-failure flag, bit 2 of offset 0x06.
- R8: Every status flag clears when software writes a 1 to its bit position. Writing 0 leaves it unchanged. If a set event and a clear happen in the same cycle, the set wins.
- R9: `irq` is high exactly while both of these are 1: the interrupt status flag, and the interrupt enable bit (bit 5 of offset 0x11). `irq` stays high until software clears the flag or the enable bit.
- R10: Control bit 9 (bit 1 of offset 0x09) holds whatever was written to it and reads back unchanged. It is not affected by timer activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base strobe |
| reg_addr | input | 5 | Byte offset within the register window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte (combinational from reg_addr) |
| irq | output | 1 | Timeout interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the following about the inputs:
- `tick_en` is a pulse no longer than one clock;
- software writes to the halt bit are the only way to freeze the count;
- only a register write can remove the interrupt.

The stimulus applies each tick as a single-cycle strobe followed by an idle cycle. It changes registers only through complete one-cycle writes, and it programs only legal initial values (3 and the reset value 4). This keeps every expiry count the bench predicts free of the behaviour for illegal values 0 and 1.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int AW = 5;
  localparam int DW = 8;

  localparam logic [AW-1:0] OFS_RELOAD = 5'h00;
  localparam logic [AW-1:0] OFS_INIT   = 5'h01;
  localparam logic [AW-1:0] OFS_STS1   = 5'h04;
  localparam logic [AW-1:0] OFS_STS2   = 5'h06;
  localparam logic [AW-1:0] OFS_CTRL   = 5'h08;
  localparam logic [AW-1:0] OFS_IEN    = 5'h10;
  localparam logic [AW-1:0] OFS_ISTS   = 5'h14;
  localparam logic [AW-1:0] OFS_NORB   = 5'h18;

  // bit positions inside the wide registers; byte lane derived below
  localparam int TO_BIT    = 3;
  localparam int SEC_BIT   = 1;
  localparam int BOOT_BIT  = 2;
  localparam int HALT_BIT  = 11;
  localparam int KEEP_BIT  = 9;
  localparam int IRQ_BIT   = 13;
  localparam int NORB_BIT  = 1;

  localparam logic [AW-1:0] ADR_STS1 = OFS_STS1 + AW'(TO_BIT / DW);
  localparam logic [AW-1:0] ADR_STS2 = OFS_STS2 + AW'(SEC_BIT / DW);
  localparam logic [AW-1:0] ADR_CTRL = OFS_CTRL + AW'(HALT_BIT / DW);
  localparam logic [AW-1:0] ADR_IEN  = OFS_IEN + AW'(IRQ_BIT / DW);
  localparam logic [AW-1:0] ADR_ISTS = OFS_ISTS + AW'(IRQ_BIT / DW);
  localparam logic [AW-1:0] ADR_NORB = OFS_NORB + AW'(NORB_BIT / DW);

  localparam int LB_TO   = TO_BIT % DW;
  localparam int LB_SEC  = SEC_BIT % DW;
  localparam int LB_BOOT = BOOT_BIT % DW;
  localparam int LB_HALT = HALT_BIT % DW;
  localparam int LB_KEEP = KEEP_BIT % DW;
  localparam int LB_IRQ  = IRQ_BIT % DW;
  localparam int LB_NORB = NORB_BIT % DW;
endpackage

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CW       = 6,
  parameter int INIT_DEF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          halt,
  input  logic          reload_req,
  input  logic [CW-1:0] init_val,
  output logic [CW-1:0] count,
  output logic          exp_first,
  output logic          exp_second
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stage_q, stage_d;

  always_comb begin
    cnt_d      = cnt_q;
    stage_d    = stage_q;
    exp_first  = 1'b0;
    exp_second = 1'b0;
    if (reload_req) begin
      cnt_d   = init_val;
      stage_d = 1'b0;
    end else if (tick_en && !halt) begin
      if (cnt_q == '0) begin
        cnt_d = init_val;
        if (stage_q) begin
          exp_second = 1'b1;
          stage_d    = 1'b0;
        end else begin
          exp_first = 1'b1;
          stage_d   = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(INIT_DEF);
      stage_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CW       = 6,
  parameter int INIT_DEF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [CW-1:0] count,
  input  logic          exp_first,
  input  logic          exp_second,
  output logic          reload_req,
  output logic [CW-1:0] init_val,
  output logic          halt,
  output logic          no_reboot,
  output logic          sec_flag,
  output logic          int_en,
  output logic          int_sts
);
  logic [CW-1:0] init_q, init_d;
  logic halt_q, halt_d, keep_q, keep_d, norb_q, norb_d;
  logic to_q, to_d, sec_q, sec_d, boot_q, boot_d;
  logic ien_q, ien_d, ists_q, ists_d;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  function automatic logic hit(input logic [AW-1:0] a);
    return reg_wr && (reg_addr == a);
  endfunction

  always_comb begin
    init_d = init_q;
    halt_d = halt_q;
    keep_d = keep_q;
    norb_d = norb_q;
    ien_d  = ien_q;
    if (hit(OFS_INIT)) init_d = reg_wdata[CW-1:0];
    if (hit(ADR_CTRL)) begin
      halt_d = reg_wdata[LB_HALT];
      keep_d = reg_wdata[LB_KEEP];
    end
    if (hit(ADR_NORB)) norb_d = reg_wdata[LB_NORB];
    if (hit(ADR_IEN))  ien_d  = reg_wdata[LB_IRQ];

    // write-one-to-clear, event set has priority
    to_d   = to_q   & ~(hit(ADR_STS1) && reg_wdata[LB_TO]);
    sec_d  = sec_q  & ~(hit(ADR_STS2) && reg_wdata[LB_SEC]);
    boot_d = boot_q & ~(hit(ADR_STS2) && reg_wdata[LB_BOOT]);
    ists_d = ists_q & ~(hit(ADR_ISTS) && reg_wdata[LB_IRQ]);
    if (exp_first) begin
      to_d   = 1'b1;
      ists_d = 1'b1;
    end
    if (exp_second) begin
      sec_d = 1'b1;
      if (sec_q) boot_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= CW'(INIT_DEF);
      halt_q <= 1'b1;
      keep_q <= 1'b0;
      norb_q <= 1'b0;
      to_q   <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
      ien_q  <= 1'b0;
      ists_q <= 1'b0;
    end else begin
      init_q <= init_d;
      halt_q <= halt_d;
      keep_q <= keep_d;
      norb_q <= norb_d;
      to_q   <= to_d;
      sec_q  <= sec_d;
      boot_q <= boot_d;
      ien_q  <= ien_d;
      ists_q <= ists_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_RELOAD: reg_rdata[CW-1:0] = count;
      OFS_INIT:   reg_rdata[CW-1:0] = init_q;
      ADR_STS1:   reg_rdata[LB_TO]  = to_q;
      ADR_STS2: begin
        reg_rdata[LB_SEC]  = sec_q;
        reg_rdata[LB_BOOT] = boot_q;
      end
      ADR_CTRL: begin
        reg_rdata[LB_HALT] = halt_q;
        reg_rdata[LB_KEEP] = keep_q;
      end
      ADR_IEN:  reg_rdata[LB_IRQ]  = ien_q;
      ADR_ISTS: reg_rdata[LB_IRQ]  = ists_q;
      ADR_NORB: reg_rdata[LB_NORB] = norb_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign reload_req = hit(OFS_RELOAD);
  assign init_val   = init_q;
  assign halt       = halt_q;
  assign no_reboot  = norb_q;
  assign sec_flag   = sec_q;
  assign int_en     = ien_q;
  assign int_sts    = ists_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int CW       = 6,
  parameter int INIT_DEF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          rst_req
);
  logic [CW-1:0] count, init_val;
  logic exp_first, exp_second, reload_req, halt, no_reboot;
  logic sec_flag, int_en, int_sts;
  logic rreq_q, rreq_d;

  wdog_core #(.CW(CW), .INIT_DEF(INIT_DEF)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt),
    .reload_req(reload_req), .init_val(init_val), .count(count),
    .exp_first(exp_first), .exp_second(exp_second)
  );

  wdog_regs #(.CW(CW), .INIT_DEF(INIT_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count),
    .exp_first(exp_first), .exp_second(exp_second),
    .reload_req(reload_req), .init_val(init_val), .halt(halt),
    .no_reboot(no_reboot), .sec_flag(sec_flag), .int_en(int_en),
    .int_sts(int_sts)
  );

  assign rreq_d = exp_second && !no_reboot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rreq_q <= 1'b0;
    else        rreq_q <= rreq_d;
  end

  assign rst_req = rreq_q;
  assign irq     = int_sts & int_en;
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [4:0]    reg_addr,
  input logic          rst_req,
  input logic          irq,
  input logic          halt,
  input logic          no_reboot,
  input logic          sec_flag,
  input logic [CW-1:0] count
);
  // R5
  rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5
  rst_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> sec_flag);

  // R6
  no_reboot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> !$past(no_reboot));

  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !(reg_wr && reg_addr == 5'h00)) |=> $stable(count));

  // R9
  irq_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .rst_req(rst_req), .irq(irq), .halt(halt), .no_reboot(no_reboot),
  .sec_flag(sec_flag), .count(count)
);

// File: tb/tb_wdog_two_stage.sv
`timescale 1ns/1ps
module tb_wdog_two_stage;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, rst_req;
  int         n_run = 0, n_fail = 0, rst_hi = 0;

  always #2.5 clk = ~clk;

  wdog_two_stage dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_n && rst_req) rst_hi++;

  // op: 0 write, 1 read-compare, 2 tick xN, 3 irq compare
  // fields: op[18:17] req[16:13] addr[12:8] data[7:0]
  localparam int NV = 27;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 4'd2,  5'h01, 8'h03},  // R2 init = 3
    {2'd0, 4'd2,  5'h00, 8'h5A},  // R2 reload
    {2'd1, 4'd2,  5'h00, 8'h03},  // R2 count = 3
    {2'd2, 4'd3,  5'h00, 8'd1},   // R3 tick while halted
    {2'd1, 4'd3,  5'h00, 8'h03},  // R3 frozen
    {2'd0, 4'd10, 5'h09, 8'h02},  // R10 clear halt, set bit 9
    {2'd1, 4'd10, 5'h09, 8'h02},  // R10 readback
    {2'd2, 4'd3,  5'h00, 8'd2},   // R3 two ticks
    {2'd1, 4'd3,  5'h00, 8'h01},  // R3 count = 1
    {2'd0, 4'd9,  5'h11, 8'h20},  // R9 enable irq
    {2'd2, 4'd4,  5'h00, 8'd2},   // R4 reach 0, then expire
    {2'd1, 4'd4,  5'h00, 8'h03},  // R4 auto reload
    {2'd1, 4'd4,  5'h04, 8'h08},  // R4 timeout flag
    {2'd1, 4'd4,  5'h15, 8'h20},  // R4 irq status
    {2'd3, 4'd9,  5'h00, 8'h01},  // R9 irq high
    {2'd1, 4'd5,  5'h06, 8'h00},  // R5 no second timeout yet
    {2'd0, 4'd8,  5'h04, 8'h08},  // R8 w1c timeout
    {2'd1, 4'd8,  5'h04, 8'h00},  // R8
    {2'd0, 4'd8,  5'h15, 8'h00},  // R8 write 0: no effect
    {2'd3, 4'd8,  5'h00, 8'h01},  // R8 irq still high
    {2'd0, 4'd9,  5'h15, 8'h20},  // R9 clear irq status
    {2'd3, 4'd9,  5'h00, 8'h00},  // R9 irq low
    {2'd0, 4'd5,  5'h00, 8'h00},  // R5 reload cancels stage
    {2'd2, 4'd5,  5'h00, 8'd4},   // R5 first expiry again
    {2'd1, 4'd5,  5'h06, 8'h00},  // R5 still no second
    {2'd2, 4'd5,  5'h00, 8'd4},   // R5 second expiry
    {2'd1, 4'd5,  5'h06, 8'h02}   // R5 second flag
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int req, input logic [4:0] a, input logic [7:0] e);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, e);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(1, 5'h09, 8'h08);
    rd(1, 5'h01, 8'h04);
    rd(1, 5'h00, 8'h04);
    rd(1, 5'h04, 8'h00);
    rd(1, 5'h06, 8'h00);
    rd(1, 5'h11, 8'h00);
    rd(1, 5'h15, 8'h00);
    rd(1, 5'h18, 8'h00);
    chk(1, {6'b0, irq, rst_req}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      int rq;
      op = VEC[v][18:17];
      rq = int'(VEC[v][16:13]);
      case (op)
        2'd0: wr(VEC[v][12:8], VEC[v][7:0]);
        2'd1: rd(rq, VEC[v][12:8], VEC[v][7:0]);
        2'd2: ticks(int'(VEC[v][7:0]));
        default: begin @(negedge clk); chk(rq, {7'b0, irq}, VEC[v][7:0]); end
      endcase
    end

    // R5 exactly one reset cycle so far
    chk(5, 8'(rst_hi), 8'd1);
    // R10 bit 9 unaffected by timer activity
    rd(10, 5'h09, 8'h02);
    wr(5'h06, 8'h02);
    rd(8, 5'h06, 8'h00);
    // R6 no-reboot suppresses pulse, flag still sets
    wr(5'h18, 8'h02);
    ticks(8);
    rd(6, 5'h06, 8'h02);
    chk(6, 8'(rst_hi), 8'd1);
    // R7 second expiry with flag already set -> boot failure
    ticks(8);
    rd(7, 5'h06, 8'h06);
    wr(5'h06, 8'h06);
    rd(8, 5'h06, 8'h00);
    // R2 reload wins over a simultaneous tick
    @(negedge clk);
    reg_addr = 5'h00; reg_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd(2, 5'h00, 8'h03);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule